// File: doc/BRIEF.md
# Serial-Loaded Converter Input Register

This block is the digital front end of a 10-bit voltage-output converter that is loaded over a three-wire serial link. A host lowers an active-low select, clocks a 16-bit word in MSB first on the rising edges of a serial clock, and raises the select again. The rising select edge moves the ten code bits into a holding register, and that register drives the converter code. The frame carries four leading pad bits, then the ten code bits, then two trailing bits that the host sends as zero.

The serial clock, select and data inputs are sampled by a system clock that runs at least four times faster than the serial clock. Each passes through a synchronizer, and edges are found by comparing successive synchronized samples. A serial output repeats the received stream. It changes on the falling serial-clock edges, so the data-out of one device can feed the data-in of the next, and several devices can share one clock and one select. An active-low clear input zeroes the held code at once, whatever the select is doing. The power-up reset zeroes the code, the shift contents and the serial output.

Top module: `sdac_frontend`

## Requirements
- R1: A 16-bit frame sent MSB first while the select is low places the code in bits [11:2] of the word. These are received bits 5 to 14, counting from 1. Raising the select makes `code_o` equal to those ten bits.
- R2: Serial-clock rising edges that arrive while the select is high shift nothing. A following frame with no clocks then reloads the unchanged previous code.
- R3: `code_o` changes only on a select rising edge or on a clear. After `cs_n_i` rises, the new code appears at the third system clock edge.
- R4: A select rising edge after more or fewer than 16 clocks loads bits [11:2] of the last 16 bits received, wherever the frame boundary lies.
- R5: While the select is low, each serial-clock falling edge sets `dout_o` to the bit received 16 rising edges earlier. Before 16 bits have arrived since reset, that bit counts as zero. The update lands on the third system clock edge after the input falls.
- R6: While the select is high, `dout_o` keeps its last value and is always driven.
- R7: A low `clr_n_i` forces `code_o` to zero without waiting for a clock edge. A select rising edge during the clear loads nothing, and the code stays zero after the clear is released.
- R8: While `rst_n` is low and after it is released, `code_o` is zero, `dout_o` is zero and the shift contents are zero.
- R9: Three devices chained data-out to data-in that receive 48 bits in one select window each hold their own code. The last device in the chain takes the first frame sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low power-up reset, asynchronous |
| sclk_i | input | 1 | Serial clock from the host |
| cs_n_i | input | 1 | Active-low frame select |
| din_i | input | 1 | Serial data in |
| clr_n_i | input | 1 | Active-low asynchronous clear of the held code |
| dout_o | output | 1 | Serial data out for chaining |
| code_o | output | CODE_W | Held converter code |

## Verification
The bench aims at the frame boundary. A frame that is too short or too long must load whatever sits in bits [11:2]. A design that counted bits from the select edge, or that cleared the shift contents between frames, would return the wrong code there. Clock pulses sent with the select high, and a select rising edge during a clear, must leave the code alone. A design that did not gate on these would show a changed code or a stray reload. The three-device chain checks the half-clock offset of the serial output. If the output moved on the wrong edge, or a bit early or late, every device would take its neighbour's code shifted by one bit.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

   typedef struct packed {
      logic sclk;
      logic cs_n;
      logic din;
   } sdac_pins_t;

   typedef struct packed {
      logic rise;
      logic fall;
   } sdac_edge_t;

   localparam sdac_pins_t PINS_IDLE = '{sclk: 1'b0, cs_n: 1'b1, din: 1'b0};

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
   parameter int          W       = 3,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] stage_q [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= RST_VAL;
            else        stage_q[g] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= RST_VAL;
            else        stage_q[g] <= stage_q[g-1];
         end
      end
   end

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sdac_edge.sv
module sdac_edge
   import sdac_pkg::*;
#(
   parameter logic RST_VAL = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       lvl_i,
   output sdac_edge_t ev_o
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= lvl_i;
   end

   assign ev_o.rise = lvl_i & ~prev_q;
   assign ev_o.fall = ~lvl_i & prev_q;
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift #(
   parameter int FRAME_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               shift_en,
   input  logic               out_en,
   input  logic               bit_i,
   output logic [FRAME_W-1:0] word_o,
   output logic               dout_o
);
   logic [FRAME_W-1:0] word_q;
   logic               dout_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        word_q <= '0;
      else if (shift_en) word_q <= {word_q[FRAME_W-2:0], bit_i};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dout_q <= 1'b0;
      else if (out_en) dout_q <= word_q[FRAME_W-1];
   end

   assign word_o = word_q;
   assign dout_o = dout_q;
endmodule

// File: rtl/sdac_hold.sv
module sdac_hold #(
   parameter int FRAME_W  = 16,
   parameter int CODE_W   = 10,
   parameter int CODE_LSB = 2
) (
   input  logic               clk,
   input  logic               arst_n,
   input  logic               load_i,
   input  logic [FRAME_W-1:0] word_i,
   output logic [CODE_W-1:0]  code_o
);
   localparam int CODE_MSB = CODE_LSB + CODE_W - 1;

   logic [CODE_W-1:0] code_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)     code_q <= '0;
      else if (load_i) code_q <= word_i[CODE_MSB:CODE_LSB];
   end

   assign code_o = code_q;
endmodule

// File: rtl/sdac_frontend.sv
module sdac_frontend
   import sdac_pkg::*;
#(
   parameter int FRAME_W     = 16,
   parameter int CODE_W      = 10,
   parameter int PAD_W       = 4,
   parameter int TAIL_W      = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_i,
   input  logic              cs_n_i,
   input  logic              din_i,
   input  logic              clr_n_i,
   output logic              dout_o,
   output logic [CODE_W-1:0] code_o
);
   localparam int PIN_W    = $bits(sdac_pins_t);
   localparam int CODE_LSB = TAIL_W;

   if (FRAME_W != PAD_W + CODE_W + TAIL_W) begin : g_bad_frame
      $error("frame width must equal pad + code + tail widths");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("at least two synchronizer stages are needed");
   end
   if (CODE_W < 1 || FRAME_W < 2) begin : g_bad_code
      $error("code and frame widths too small");
   end

   sdac_pins_t         pins_raw, pins_s;
   logic [PIN_W-1:0]   pins_q;
   sdac_edge_t         sclk_ev, cs_ev;
   logic               cs_s;
   logic [FRAME_W-1:0] shreg;
   logic               hold_rst_n;

   assign pins_raw = '{sclk: sclk_i, cs_n: cs_n_i, din: din_i};

   sdac_sync #(
      .W      (PIN_W),
      .STAGES (SYNC_STAGES),
      .RST_VAL(PINS_IDLE)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (pins_raw),
      .q_o  (pins_q)
   );

   assign pins_s = sdac_pins_t'(pins_q);
   assign cs_s   = pins_s.cs_n;

   sdac_edge #(.RST_VAL(PINS_IDLE.sclk)) u_sclk_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl_i(pins_s.sclk),
      .ev_o (sclk_ev)
   );

   sdac_edge #(.RST_VAL(PINS_IDLE.cs_n)) u_cs_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl_i(pins_s.cs_n),
      .ev_o (cs_ev)
   );

   sdac_shift #(.FRAME_W(FRAME_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_en(sclk_ev.rise & ~cs_s),
      .out_en  (sclk_ev.fall & ~cs_s),
      .bit_i   (pins_s.din),
      .word_o  (shreg),
      .dout_o  (dout_o)
   );

   assign hold_rst_n = rst_n & clr_n_i;

   sdac_hold #(
      .FRAME_W (FRAME_W),
      .CODE_W  (CODE_W),
      .CODE_LSB(CODE_LSB)
   ) u_hold (
      .clk   (clk),
      .arst_n(hold_rst_n),
      .load_i(cs_ev.rise),
      .word_i(shreg),
      .code_o(code_o)
   );
endmodule

// File: rtl/sdac_frontend_chk.sv
module sdac_frontend_chk #(
   parameter int FRAME_W = 16,
   parameter int CODE_W  = 10
) (
   input logic               clk,
   input logic               rst_n,
   input logic               clr_n_i,
   input logic               cs_s,
   input logic               cs_rise,
   input logic               sclk_rise,
   input logic [FRAME_W-1:0] shreg,
   input logic               dout_o,
   input logic [CODE_W-1:0]  code_o
);
   // R2
   shift_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sclk_rise || cs_s) |=> $stable(shreg));

   // R3
   code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n_i && !cs_rise) |=> (!clr_n_i || $stable(code_o)));

   // R6
   dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> $stable(dout_o));

   // R7
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n_i |-> (code_o == '0));

   // R8
   reset_zero_chk: assert property (@(posedge clk)
      !rst_n |-> (code_o == '0 && dout_o == 1'b0 && shreg == '0));
endmodule

bind sdac_frontend sdac_frontend_chk #(
   .FRAME_W(FRAME_W),
   .CODE_W (CODE_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .clr_n_i  (clr_n_i),
   .cs_s     (cs_s),
   .cs_rise  (cs_ev.rise),
   .sclk_rise(sclk_ev.rise),
   .shreg    (shreg),
   .dout_o   (dout_o),
   .code_o   (code_o)
);

// File: tb/sdac_frontend_bench.sv
module sdac_frontend_bench;
   logic clk = 1'b0;
   logic rst_n, sclk, cs_n, din, clr_n;
   logic dout0, dout1, dout2;
   logic [9:0] code0, code1, code2;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   bit         hist[$];
   logic [9:0] exp_code;
   logic       exp_dout;
   bit         cs_m;

   always #5 clk = ~clk;

   sdac_frontend u_sdac_frontend (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .din_i(din),
      .clr_n_i(clr_n), .dout_o(dout0), .code_o(code0));

   sdac_frontend u_chain1 (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .din_i(dout0),
      .clr_n_i(clr_n), .dout_o(dout1), .code_o(code1));

   sdac_frontend u_chain2 (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .din_i(dout1),
      .clr_n_i(clr_n), .dout_o(dout2), .code_o(code2));

   task automatic chk(input string tag, input logic [9:0] act, input logic [9:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // reference model: code taken from positions [11:2] of the last 16 bits
   function automatic logic [9:0] model_code();
      logic [9:0] r;
      for (int j = 0; j < 10; j++) r[j] = hist[hist.size() - 3 - j];
      return r;
   endfunction

   task automatic model_reset();
      hist.delete();
      for (int i = 0; i < 16; i++) hist.push_back(1'b0);
      exp_code = '0;
      exp_dout = 1'b0;
      cs_m     = 1'b1;
   endtask

   // every clock: R3 for the code, R5 and R6 for the serial output
   always @(negedge clk) begin
      if (!done) begin
         compared++;
         if (code0 !== exp_code) begin
            mismatched++;
            $display("FAIL R3 code actual=%h expected=%h at %0t", code0, exp_code, $time);
         end
         compared++;
         if (dout0 !== exp_dout) begin
            mismatched++;
            $display("FAIL R5 dout actual=%b expected=%b at %0t", dout0, exp_dout, $time);
         end
      end
   end

   task automatic settle();
      repeat (3) @(posedge clk);
      #1;
   endtask

   task automatic set_cs(input logic v);
      @(negedge clk);
      cs_n = v;
      settle();
      if (v && !cs_m && clr_n) exp_code = model_code();
      cs_m = v;
      @(negedge clk);
   endtask

   task automatic put_bit(input logic b);
      @(negedge clk);
      din  = b;
      sclk = 1'b1;
      settle();
      if (!cs_m) hist.push_back(b);
      @(negedge clk);
      sclk = 1'b0;
      settle();
      if (!cs_m) exp_dout = hist[hist.size() - 16];
      @(negedge clk);
   endtask

   task automatic send(input logic [31:0] bits, input int n);
      for (int i = n - 1; i >= 0; i--) put_bit(bits[i]);
   endtask

   task automatic frame(input logic [3:0] pad, input logic [9:0] code);
      set_cs(1'b0);
      send({16'h0, pad, code, 2'b00}, 16);
      set_cs(1'b1);
   endtask

   task automatic set_clr(input logic v);
      @(posedge clk);
      #2;
      clr_n = v;
      if (!v) exp_code = '0;
      @(negedge clk);
   endtask

   task automatic do_reset();
      @(posedge clk);
      #2;
      rst_n = 1'b0;
      model_reset();
      repeat (3) @(posedge clk);
      #2;
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; din = 1'b0; clr_n = 1'b1;
      model_reset();
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);

      // R8 reset state
      chk("R8 code after reset", code0, 10'h000);
      chk("R8 dout after reset", {9'h0, dout0}, 10'h000);

      // R1 plain frames
      frame(4'h0, 10'h2A5);
      chk("R1 frame 2A5", code0, 10'h2A5);
      frame(4'hA, 10'h3FF);
      chk("R1 frame 3FF", code0, 10'h3FF);

      // R2 clocks with select high shift nothing; R6 dout holds
      send(32'h0000_00C3, 8);
      chk("R6 dout held while select high", {9'h0, dout0}, 10'h001);
      set_cs(1'b0);
      set_cs(1'b1);
      chk("R2 empty frame reloads old code", code0, 10'h3FF);

      // R4 long frame: four extra bits ahead of the frame
      set_cs(1'b0);
      send(32'hF, 4);
      send({16'h0, 4'h0, 10'h155, 2'b00}, 16);
      set_cs(1'b1);
      chk("R4 long frame", code0, 10'h155);

      // R4 short frame: eight zeros after word 0x0554 gives 0x5400
      set_cs(1'b0);
      send(32'h0, 8);
      set_cs(1'b1);
      chk("R4 short frame", code0, 10'h100);

      // R7 clear, independent of select
      set_clr(1'b0);
      chk("R7 clear zeroes code", code0, 10'h000);
      frame(4'h0, 10'h0F0);
      chk("R7 select edge ignored during clear", code0, 10'h000);
      set_clr(1'b1);
      chk("R7 code stays zero after release", code0, 10'h000);
      frame(4'h5, 10'h0F0);
      chk("R3 load after clear released", code0, 10'h0F0);

      // R8 reset in mid-run
      do_reset();
      chk("R8 code after second reset", code0, 10'h000);
      chk("R8 dout after second reset", {9'h0, dout0}, 10'h000);

      // R9 chain of three, farthest device first
      set_cs(1'b0);
      send({16'h0, 4'h3, 10'h311, 2'b00}, 16);
      send({16'h0, 4'hC, 10'h0CC, 2'b00}, 16);
      send({16'h0, 4'h9, 10'h2F5, 2'b00}, 16);
      set_cs(1'b1);
      chk("R9 last device code", code2, 10'h311);
      chk("R9 middle device code", code1, 10'h0CC);
      chk("R9 first device code", code0, 10'h2F5);

      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule